// File: doc/BRIEF.md
# GPIO Controller with Edge-Triggered Interrupts

This block is a 32-line general-purpose I/O controller. Software reaches it through a simple word-wide register port that has a single-cycle write strobe and a registered read. Each line can be an output driven from a stored data bit or an input sampled from its pad. Input lines pass through a two-stage synchroniser. A change on a synchronised input line can latch a per-line event. The block raises one interrupt output while any event that software has unmasked is still pending.

Line numbering is reversed against register bit numbering: line n occupies register bit 31-n in every per-line register. The pad vectors (`pinIn`, `pinOut`, `pinOe`) are indexed by line number. Each line has an edge-select bit. It picks either falling edges only or both edges. An input reaches the data register and the edge detector only when its input-buffer-enable bit is set. Software clears a pending event by writing a 1 to its bit.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pinOe` is 0 and `irq` is 0.
- R2: Line n maps to register bit 31-n in every per-line register. `pinOe[n]`, `pinOut[n]` and `pinIn[n]` belong to line n.
- R3: A direction bit of 1 (word offset 0x00) makes the line an output: `pinOe` is set and `pinOut` carries the stored data bit. A direction bit of 0 makes the line an input.
- R4: For an input line, the data register (offset 0x08) reads the synchronised pin only when the line's input-buffer-enable bit (offset 0x18) is 1. Otherwise the bit reads 0.
- R5: A data read returns the stored value on output lines and the sampled pin on input lines, merged bit by bit under the direction mask.
- R6: The edge-select register is at offset 0x14. A bit of 1 latches an event (offset 0x0C) only on a falling edge. A bit of 0 latches an event on either edge.
- R7: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R8: `irq` is high exactly while (event AND mask) is non-zero. The mask is at offset 0x10, and a mask bit of 1 enables the line.
- R9: Offset 0x04 and the unused offset 0x1C read 0. Writes to them change nothing.
- R10: When an edge and a clearing write reach the same event bit in the same cycle, the bit stays set.
- R11: No event is latched for a line that is an output or whose input buffer is disabled.
- R12: An event, and through it `irq`, appears on the third rising clock edge after a pin change. Read data appears one clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address of the register word |
| busWrite | input | 1 | Single-cycle write strobe |
| busRead | input | 1 | Read strobe; data is returned on the next clock |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| pinIn | input | 32 | Pad input values, indexed by line |
| pinOut | output | 32 | Pad output values, indexed by line |
| pinOe | output | 32 | Pad output enables, indexed by line |
| irq | output | 1 | Interrupt output, high while an unmasked event is pending |

## Verification
A corrupted event bit is the internal fault with the largest reach. It appears on `irq` in the cycle after the fault whenever the line is unmasked. A masked line shows it only when software reads the event word, which costs one registered read cycle. A fault in the synchroniser or in the edge history moves event capture away from the three-edge latency. It can also create a phantom event on a gated line. The bench measures `irq` cycle by cycle across a pin change and during a clear that collides with a new edge. Faults in the direction or buffer-enable registers appear at once on `pinOe` and in the merged data word.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  // word index (byte address bits [4:2]) of each register
  typedef enum logic [2:0] {
    SEL_DIR  = 3'd0,
    SEL_OPEN = 3'd1,
    SEL_DATA = 3'd2,
    SEL_EVT  = 3'd3,
    SEL_MASK = 3'd4,
    SEL_EDGE = 3'd5,
    SEL_IBE  = 3'd6,
    SEL_NONE = 3'd7
  } regSel_e;

  // strobes passed from the decode to the datapath
  typedef struct packed {
    logic    wrDir;
    logic    wrData;
    logic    wrEvt;
    logic    wrMask;
    logic    wrEdge;
    logic    wrIbe;
    logic    rdEn;
    regSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/gpio_edge_decode.sv
module gpio_edge_decode
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  output busStrobe_t        strobe
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int NUM_WORDS = 7;

  logic [IDX_W-1:0] wordIdx;
  logic             inMap;
  regSel_e          sel;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign inMap   = (int'(wordIdx) < NUM_WORDS);

  always_comb begin
    sel = SEL_NONE;
    if (inMap) sel = regSel_e'(wordIdx[2:0]);
  end

  always_comb begin
    strobe        = '0;
    strobe.wrDir  = busWrite && (sel == SEL_DIR);
    strobe.wrData = busWrite && (sel == SEL_DATA);
    strobe.wrEvt  = busWrite && (sel == SEL_EVT);
    strobe.wrMask = busWrite && (sel == SEL_MASK);
    strobe.wrEdge = busWrite && (sel == SEL_EDGE);
    strobe.wrIbe  = busWrite && (sel == SEL_IBE);
    strobe.rdEn   = busRead;
    strobe.rdSel  = sel;
  end

endmodule

// File: rtl/gpio_edge_datapath.sv
module gpio_edge_datapath
  import gpio_edge_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobe_t           strobe,
  input  logic [NUM_LINES-1:0] busWdata,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOe,
  output logic                 irq,
  output logic [NUM_LINES-1:0] busRdata
);

  localparam int TOP = NUM_LINES - 1;

  // all vectors below are in register bit order (line n at bit TOP-n)
  logic [TOP:0] dirReg, dataReg, evtReg, maskReg, edgeReg, ibeReg;
  logic [TOP:0] pinRegOrder;
  logic [TOP:0] syncPipe [SYNC_STAGES];
  logic [TOP:0] sampled, prevSample;
  logic [TOP:0] eligible, rise, fall, edgeHit, clrMask, evtNext, dataView;

  // line n <-> register bit TOP-n
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_lineMap
    assign pinRegOrder[TOP-n] = pinIn[n];
    assign pinOe[n]           = dirReg[TOP-n];
    assign pinOut[n]          = dataReg[TOP-n];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= '0;
      prevSample <= '0;
    end else begin
      syncPipe[0] <= pinRegOrder;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
      prevSample <= sampled;
    end
  end

  assign sampled  = syncPipe[SYNC_STAGES-1];
  assign eligible = ~dirReg & ibeReg;
  assign rise     = sampled & ~prevSample;
  assign fall     = ~sampled & prevSample;
  assign edgeHit  = eligible & ((rise & ~edgeReg) | fall);
  assign clrMask  = strobe.wrEvt ? busWdata : '0;
  assign evtNext  = (evtReg & ~clrMask) | edgeHit;
  assign dataView = (dataReg & dirReg) | (sampled & eligible);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg  <= '0;
      dataReg <= '0;
      evtReg  <= '0;
      maskReg <= '0;
      edgeReg <= '0;
      ibeReg  <= '0;
    end else begin
      if (strobe.wrDir)  dirReg  <= busWdata;
      if (strobe.wrData) dataReg <= busWdata;
      if (strobe.wrMask) maskReg <= busWdata;
      if (strobe.wrEdge) edgeReg <= busWdata;
      if (strobe.wrIbe)  ibeReg  <= busWdata;
      evtReg <= evtNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (strobe.rdEn) begin
      unique case (strobe.rdSel)
        SEL_DIR:  busRdata <= dirReg;
        SEL_DATA: busRdata <= dataView;
        SEL_EVT:  busRdata <= evtReg;
        SEL_MASK: busRdata <= maskReg;
        SEL_EDGE: busRdata <= edgeReg;
        SEL_IBE:  busRdata <= ibeReg;
        default:  busRdata <= '0;
      endcase
    end
  end

  assign irq = |(evtReg & maskReg);

  // an event bit only drops where a 1 was written to it
  a_r7_clear_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(evtReg) & ~evtReg) & ~$past(clrMask)) == '0));

  // newly latched events only on gated-in input lines
  a_r11_gated_capture: assert property (@(posedge clk) disable iff (!rstN)
    (((evtReg & ~$past(evtReg)) & ~$past(eligible)) == '0));

  // a detected edge always lands, whatever write came with it
  a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rstN)
    (($past(edgeHit) & ~evtReg) == '0));

  // falling-only lines never latch on a rise
  a_r6_falling_only: assert property (@(posedge clk) disable iff (!rstN)
    (((evtReg & ~$past(evtReg)) & $past(edgeReg) & ~$past(fall)) == '0));

  // the interrupt only drops after an event clear or a mask change
  a_r8_irq_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(strobe.wrEvt || strobe.wrMask));

  // read data holds between read strobes
  a_r12_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.rdEn) |-> $stable(busRdata));

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrite,
  input  logic                 busRead,
  input  logic [NUM_LINES-1:0] busWdata,
  output logic [NUM_LINES-1:0] busRdata,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOe,
  output logic                 irq
);

  busStrobe_t strobe;

  gpio_edge_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .busRead  (busRead),
    .strobe   (strobe)
  );

  gpio_edge_datapath #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irq      (irq),
    .busRdata (busRdata)
  );

endmodule

// File: tb/gpio_edge_ctrl_test.sv
module gpio_edge_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic        busRead = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_edge_ctrl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  // vector: {write, byte address, data, expected read}
  localparam int NV = 16;
  localparam logic [72:0] VECS [NV] = '{
    {1'b1, 8'h00, 32'hC000_0000, 32'h0},          // R3 lines 0,1 outputs
    {1'b0, 8'h00, 32'h0,         32'hC000_0000},
    {1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0},          // R9 open slot
    {1'b0, 8'h04, 32'h0,         32'h0},
    {1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h08, 32'h0,         32'hC000_0000},  // R4/R5 inputs gated to 0
    {1'b1, 8'h10, 32'h5A5A_0000, 32'h0},
    {1'b0, 8'h10, 32'h0,         32'h5A5A_0000},
    {1'b1, 8'h14, 32'h0000_FFFF, 32'h0},
    {1'b0, 8'h14, 32'h0,         32'h0000_FFFF},
    {1'b1, 8'h10, 32'h0,         32'h0},
    {1'b1, 8'h14, 32'h0,         32'h0},
    {1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h18, 32'h0,         32'hFFFF_FFFF},
    {1'b0, 8'h1C, 32'h0,         32'h0},          // R9 unused slot
    {1'b0, 8'h0C, 32'h0,         32'h0}           // no events yet
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks are entered just after a falling edge
  task automatic busWr(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a; busRead = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busRead = 1'b0;
    d = busRdata;
  endtask

  task automatic rdCheck(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRd(a, v);
    check(req, v, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pinOe", pinOe, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    for (int a = 0; a < 8; a++) rdCheck("R1 register", 5'(a * 4), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][72]) busWr(VECS[i][68:64], VECS[i][63:32]);
      else rdCheck($sformatf("R9/R3/R4 table vector %0d", i), VECS[i][68:64], VECS[i][31:0]);
    end

    // R2/R3 pad side: register bits 31,30 are lines 0,1
    check("R2 pinOe", pinOe, 32'h0000_0003);
    check("R3 pinOut", pinOut & pinOe, 32'h0000_0003);

    // R5/R6 inputs: lines 4..7 rise
    pinIn = 32'h0000_00F0;
    settle();
    rdCheck("R5 merged data", 5'h08, 32'hCF00_0000);
    rdCheck("R6 both-edge capture", 5'h0C, 32'h0F00_0000);
    check("R8 irq masked", {31'h0, irq}, 32'h0);

    // R11 output line toggle creates no event
    pinIn = 32'h0000_00F1;
    settle();
    rdCheck("R11 output line", 5'h0C, 32'h0F00_0000);

    busWr(5'h10, 32'h0100_0000);
    check("R8 irq unmasked", {31'h0, irq}, 32'h1);
    busWr(5'h0C, 32'h0);
    rdCheck("R7 zero write", 5'h0C, 32'h0F00_0000);
    busWr(5'h0C, 32'h0E00_0000);
    rdCheck("R7 partial clear", 5'h0C, 32'h0100_0000);
    check("R8 irq still set", {31'h0, irq}, 32'h1);
    busWr(5'h0C, 32'h0100_0000);
    rdCheck("R7 full clear", 5'h0C, 32'h0);
    check("R8 irq cleared", {31'h0, irq}, 32'h0);

    // R6 falling-only on line 8
    busWr(5'h14, 32'hFFFF_FFFF);
    pinIn = 32'h0000_01F1;
    settle();
    rdCheck("R6 rise ignored", 5'h0C, 32'h0);
    pinIn = 32'h0000_00F1;
    settle();
    rdCheck("R6 fall captured", 5'h0C, 32'h0080_0000);
    busWr(5'h0C, 32'hFFFF_FFFF);

    // R4/R11 buffer disabled on line 9
    busWr(5'h14, 32'h0);
    busWr(5'h18, 32'hFFBF_FFFF);
    pinIn = 32'h0000_02F1;
    settle();
    rdCheck("R11 buffer off", 5'h0C, 32'h0);
    rdCheck("R4 buffer off", 5'h08, 32'hCF00_0000);
    busWr(5'h18, 32'hFFFF_FFFF);
    settle();
    rdCheck("R4 buffer on", 5'h08, 32'hCF40_0000);
    rdCheck("R11 enable no event", 5'h0C, 32'h0);

    // R12 latency on line 10
    busWr(5'h10, 32'h0020_0000);
    pinIn = 32'h0000_06F1;
    @(negedge clk);
    check("R12 edge 1", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R12 edge 2", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R12 edge 3", {31'h0, irq}, 32'h1);
    busWr(5'h0C, 32'h0020_0000);
    check("R7 clear line 10", {31'h0, irq}, 32'h0);

    // R10 clear collides with new falling edge
    pinIn = 32'h0000_02F1;
    @(negedge clk);
    @(negedge clk);
    busWr(5'h0C, 32'h0020_0000);
    check("R10 irq held", {31'h0, irq}, 32'h1);
    rdCheck("R10 event held", 5'h0C, 32'h0020_0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule